// File: doc/BRIEF.md
# Histogram Delay-Line Calibrator

This block builds the fine-time lookup table for a tapped-delay-line time converter by code density. After reset, and again on each restart command, it clears one hit counter per tap. It then collects the encoder's leading-run tap counts while randomly timed pulses are fed into the delay line. Because the pulses are random, the number of hits a tap collects is proportional to that tap's bin width. Once a power-of-two number of hits has been gathered, a running sum over the bins gives each tap's position in the clock period. The block writes each tap's midpoint, as a 13-bit fraction of the clock period, into the table.

After the table is filled, the block counts the compensation ring oscillator's strobes over a fixed window and holds that count as the reference for later drift correction. The calibrator is shared by all channels. Its busy output tells every channel to keep its results invalid until the done flag rises.

Top module: `hdc_calibrator`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `cal_busy` is 1, `cal_done` is 0, `lut_we` is 0 and `ref_freq` is 0. Calibration then starts without any command.
- R2: A one-cycle pulse on `cal_cmd` in any state restarts calibration. On the next cycle `cal_busy` is 1 and `cal_done` is 0. Hits gathered before the pulse do not contribute to the table.
- R3: Clearing the bins takes TAPS cycles after the start. After that, a cycle with `tap_valid`=1 and `tap_count` < TAPS adds one hit to bin `tap_count`. A `tap_count` ≥ TAPS, or a cycle with `tap_valid`=0, adds nothing.
- R4: Accumulation ends on exactly the 2^NLOG-th accepted hit. Strobes that arrive after it have no effect on the table.
- R5: The table is written once per tap, at addresses 0 to TAPS-1 in ascending order. Entry i is (2·S_i + H_i)·2^13 / 2^(NLOG+1), truncated, where H_i is the hit count of bin i and S_i is the sum of H_0 to H_(i-1).
- R6: An entry whose value would reach 2^13 is written as 8191.
- R7: `lut_we` is never high on two consecutive cycles.
- R8: After the last table write, the block counts the cycles with `ro_pulse`=1 over a window of exactly 2^RLOG cycles. It loads that count into `ref_freq`, which holds it until the next measurement ends.
- R9: After the measurement, `cal_done` is 1 and `cal_busy` is 0 until the next `cal_cmd`. No table writes occur in that time, and `ref_freq` does not change.
- R10: `cal_busy` stays 1 from reset or `cal_cmd` until `cal_done` rises, and every table write happens while `cal_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_cmd | input | 1 | Restart calibration |
| tap_valid | input | 1 | Encoder tap count valid |
| tap_count | input | $clog2(TAPS)+1 | Leading-run length from the encoder |
| ro_pulse | input | 1 | Ring oscillator strobe |
| lut_we | output | 1 | Table write enable |
| lut_addr | output | $clog2(TAPS) | Table write address (tap) |
| lut_data | output | 13 | Tap midpoint as a fraction of the clock period |
| ref_freq | output | RLOG+1 | Stored ring oscillator count |
| cal_busy | output | 1 | Calibration in progress; channel outputs invalid |
| cal_done | output | 1 | Calibration finished |

## Verification
A skewed random spread of hits, with out-of-range counts and idle cycles mixed in, checks that the cumulative midpoints follow the actual bin widths and not equal widths. A run that puts every hit on a single tap drives later entries into saturation and separates the zero, half-period and clipped values. A restart in the middle of accumulation, with hits only on tap 0 beforehand, shows whether stale bins leak into the table. Three ring oscillator patterns (always high, alternating, always low) tell an exact-window count apart from an off-by-one window. Strobes sent after completion confirm that the table and the reference stay frozen.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
    localparam int unsigned FRAC_W = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ACCUM,
        ST_INTEG,
        ST_WRITE,
        ST_MEAS,
        ST_DONE
    } cal_state_e;
endpackage

// File: rtl/hdc_hist_bank.sv
module hdc_hist_bank #(
    parameter int unsigned TAPS  = 64,
    parameter int unsigned BIN_W = 11,
    localparam int unsigned IDX_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             inc_en,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [BIN_W-1:0] rd_bin
);
    logic [BIN_W-1:0] bin_arr [TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_bin
        logic [BIN_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (clr_en && clr_idx == IDX_W'(g))
                cnt_q <= '0;
            else if (inc_en && inc_idx == IDX_W'(g))
                cnt_q <= cnt_q + 1'b1;
        end
        assign bin_arr[g] = cnt_q;
    end

    assign rd_bin = bin_arr[rd_idx];
endmodule

// File: rtl/hdc_integrator.sv
module hdc_integrator #(
    parameter int unsigned NLOG   = 10,
    parameter int unsigned FRAC_W = 13,
    localparam int unsigned BIN_W = NLOG + 1,
    localparam int unsigned MID_W = NLOG + 2,
    localparam int unsigned SC_W  = MID_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic [BIN_W-1:0]  bin_in,
    output logic [FRAC_W-1:0] frac_q
);
    logic [BIN_W-1:0] sum_q;
    logic [MID_W-1:0] mid;
    logic [SC_W-1:0]  scaled;
    logic [FRAC_W-1:0] frac_d;

    // midpoint of bin: 2*prefix + width, in units of half a hit
    assign mid    = {sum_q, 1'b0} + MID_W'(bin_in);
    assign scaled = {mid, {FRAC_W{1'b0}}} >> (NLOG + 1);
    assign frac_d = (|scaled[SC_W-1:FRAC_W]) ? {FRAC_W{1'b1}} : scaled[FRAC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_q  <= '0;
            frac_q <= '0;
        end else if (step) begin
            sum_q  <= sum_q + bin_in;
            frac_q <= frac_d;
        end
    end

    // R5
    prefix_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sum_q <= BIN_W'(2 ** NLOG));
endmodule

// File: rtl/hdc_ref_meter.sv
module hdc_ref_meter #(
    parameter int unsigned RLOG = 8,
    localparam int unsigned CNT_W = RLOG + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ro_pulse,
    output logic             fin,
    output logic [CNT_W-1:0] ref_q
);
    logic [RLOG-1:0]  tmr_q;
    logic [CNT_W-1:0] acc_q;

    assign fin = run && (tmr_q == {RLOG{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tmr_q <= '0;
            acc_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
            acc_q <= acc_q + CNT_W'(ro_pulse);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ref_q <= '0;
        else if (fin)
            ref_q <= acc_q + CNT_W'(ro_pulse);
    end

    // R8
    ref_load_chk: assert property (@(posedge clk) disable iff (rst)
        !fin |=> $stable(ref_q));
endmodule

// File: rtl/hdc_calibrator.sv
module hdc_calibrator
    import hdc_pkg::*;
#(
    parameter int unsigned TAPS = 64,
    parameter int unsigned NLOG = 10,
    parameter int unsigned RLOG = 8,
    localparam int unsigned IDX_W = $clog2(TAPS),
    localparam int unsigned TC_W  = IDX_W + 1,
    localparam int unsigned BIN_W = NLOG + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_cmd,
    input  logic              tap_valid,
    input  logic [TC_W-1:0]   tap_count,
    input  logic              ro_pulse,
    output logic              lut_we,
    output logic [IDX_W-1:0]  lut_addr,
    output logic [FRAC_W-1:0] lut_data,
    output logic [RLOG:0]     ref_freq,
    output logic              cal_busy,
    output logic              cal_done
);
    cal_state_e       st_q;
    logic [IDX_W-1:0] idx_q;
    logic [BIN_W-1:0] samp_q;
    logic             accept;
    logic             last_hit;
    logic             last_idx;
    logic [BIN_W-1:0] rd_bin;
    logic             meas_fin;

    assign accept   = (st_q == ST_ACCUM) && tap_valid && (tap_count < TC_W'(TAPS));
    assign last_hit = accept && (samp_q == BIN_W'(2 ** NLOG - 1));
    assign last_idx = (idx_q == IDX_W'(TAPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            samp_q <= '0;
        end else if (cal_cmd) begin
            st_q   <= ST_CLEAR;
            idx_q  <= '0;
            samp_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    st_q  <= ST_CLEAR;
                    idx_q <= '0;
                end
                ST_CLEAR: begin
                    idx_q <= idx_q + 1'b1;
                    if (last_idx) begin
                        st_q   <= ST_ACCUM;
                        samp_q <= '0;
                    end
                end
                ST_ACCUM: begin
                    if (accept) samp_q <= samp_q + 1'b1;
                    if (last_hit) begin
                        st_q  <= ST_INTEG;
                        idx_q <= '0;
                    end
                end
                ST_INTEG: st_q <= ST_WRITE;
                ST_WRITE: begin
                    if (last_idx) begin
                        st_q <= ST_MEAS;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= ST_INTEG;
                    end
                end
                ST_MEAS: if (meas_fin) st_q <= ST_DONE;
                ST_DONE: st_q <= ST_DONE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    hdc_hist_bank #(.TAPS(TAPS), .BIN_W(BIN_W)) u_bank (
        .clk     (clk),
        .clr_en  (st_q == ST_CLEAR),
        .clr_idx (idx_q),
        .inc_en  (accept),
        .inc_idx (tap_count[IDX_W-1:0]),
        .rd_idx  (idx_q),
        .rd_bin  (rd_bin)
    );

    hdc_integrator #(.NLOG(NLOG), .FRAC_W(FRAC_W)) u_integ (
        .clk    (clk),
        .rst    (rst),
        .clr    (st_q == ST_CLEAR),
        .step   (st_q == ST_INTEG),
        .bin_in (rd_bin),
        .frac_q (lut_data)
    );

    hdc_ref_meter #(.RLOG(RLOG)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .run      (st_q == ST_MEAS),
        .ro_pulse (ro_pulse),
        .fin      (meas_fin),
        .ref_q    (ref_freq)
    );

    assign lut_we   = (st_q == ST_WRITE);
    assign lut_addr = idx_q;
    assign cal_done = (st_q == ST_DONE);
    assign cal_busy = !cal_done;

    // R4
    hit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        samp_q <= BIN_W'(2 ** NLOG));

    // R7
    write_gap_chk: assert property (@(posedge clk) disable iff (rst)
        lut_we |=> !lut_we);

    // R10
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        lut_we |-> cal_busy);

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        cal_cmd |=> (cal_busy && !cal_done && !lut_we));

    // R9
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_done && $past(cal_done)) |-> ($stable(ref_freq) && !lut_we));
endmodule

// File: tb/hdc_calibrator_test.sv
module hdc_calibrator_test;
    localparam int TAPS = 64;
    localparam int NLOG = 10;
    localparam int RLOG = 8;
    localparam int IDX_W = $clog2(TAPS);
    localparam int TC_W = IDX_W + 1;
    localparam int CLK_PERIOD = 10;
    localparam int NHITS = 2 ** NLOG;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cal_cmd = 1'b0;
    logic tap_valid = 1'b0;
    logic [TC_W-1:0] tap_count = '0;
    logic ro_pulse = 1'b0;
    logic lut_we;
    logic [IDX_W-1:0] lut_addr;
    logic [12:0] lut_data;
    logic [RLOG:0] ref_freq;
    logic cal_busy;
    logic cal_done;

    int checks = 0;
    int fails = 0;
    int ro_mode = 0;
    int hist [TAPS];
    int got [TAPS];
    int wr_next = 0;
    int order_err = 0;
    int cyc = 0;

    hdc_calibrator #(.TAPS(TAPS), .NLOG(NLOG), .RLOG(RLOG)) uut (
        .clk(clk), .rst(rst), .cal_cmd(cal_cmd), .tap_valid(tap_valid),
        .tap_count(tap_count), .ro_pulse(ro_pulse), .lut_we(lut_we),
        .lut_addr(lut_addr), .lut_data(lut_data), .ref_freq(ref_freq),
        .cal_busy(cal_busy), .cal_done(cal_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (lut_we) begin
            if (int'(lut_addr) != wr_next) order_err <= order_err + 1;
            got[lut_addr] <= int'(lut_data);
            wr_next <= wr_next + 1;
        end
    end

    function automatic int exp_entry(int i);
        longint s = 0;
        longint v;
        for (int k = 0; k < i; k++) s += hist[k];
        v = ((2 * s + hist[i]) * (longint'(1) << 13)) >> (NLOG + 1);
        if (v > 8191) v = 8191;
        return int'(v);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < TAPS; k++) begin
            hist[k] = 0;
            got[k] = -1;
        end
        wr_next = 0;
        order_err = 0;
    endtask

    // mode 0: skewed random, mode 1: all on tap 5, mode 2: edge clusters
    task automatic feed(int mode, int limit);
        int acc = 0;
        while (acc < limit) begin
            @(negedge clk);
            tap_valid = ($urandom % 4) != 0;
            if (($urandom % 10) == 0)
                tap_count = TC_W'(TAPS);
            else if (mode == 0)
                tap_count = TC_W'((($urandom % TAPS) * ($urandom % TAPS)) / TAPS);
            else if (mode == 1)
                tap_count = TC_W'(5);
            else
                tap_count = TC_W'((($urandom % 2) == 0) ? ($urandom % 3) : (TAPS - 1));
            if (tap_valid && int'(tap_count) < TAPS) begin
                hist[tap_count] += 1;
                acc++;
            end
        end
    endtask

    task automatic finish_cal(int mode, string tag);
        feed(mode, NHITS);
        // extra strobes after the last counted hit: R4
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            tap_valid = 1'b1;
            tap_count = TC_W'(TAPS - 1);
        end
        @(negedge clk);
        tap_valid = 1'b0;
        // R10
        check({tag, " R10 busy while calibrating"}, int'(cal_busy), 1);
        while (!cal_done && cyc < 150000) @(negedge clk);
    endtask

    task automatic check_table(string tag);
        check({tag, " R5 writes in order"}, order_err, 0);
        check({tag, " R5 write count"}, wr_next, TAPS);
        for (int i = 0; i < TAPS; i++)
            check({tag, " R5/R6 entry"}, got[i], exp_entry(i));
    endtask

    task automatic restart();
        @(negedge clk);
        cal_cmd = 1'b1;
        tap_valid = 1'b0;
        @(negedge clk);
        cal_cmd = 1'b0;
        check("R2 busy after command", int'(cal_busy), 1);
        check("R2 done low after command", int'(cal_done), 0);
        clear_model();
        repeat (TAPS + 2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20250));
        clear_model();
        fork
            forever begin
                @(negedge clk);
                if (ro_mode == 0) ro_pulse = 1'b1;
                else if (ro_mode == 1) ro_pulse = ~ro_pulse;
                else ro_pulse = 1'b0;
            end
            begin
                wait (cyc >= 150000);
                fails++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(cal_busy), 1);
        check("R1 done in reset", int'(cal_done), 0);
        check("R1 no write in reset", int'(lut_we), 0);
        check("R1 ref in reset", int'(ref_freq), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", int'(cal_busy), 1);
        check("R1 no write after reset", int'(lut_we), 0);
        repeat (TAPS + 3) @(negedge clk);

        // startup run, skewed random hits (R3)
        ro_mode = 0;
        finish_cal(0, "A");
        check("A R9 done", int'(cal_done), 1);
        check("A R9 busy low", int'(cal_busy), 0);
        check_table("A");
        check("A R8 ref all-high", int'(ref_freq), 2 ** RLOG);

        // R9: strobes after done change nothing
        wr_next = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            tap_valid = 1'b1;
            tap_count = TC_W'(k % TAPS);
        end
        @(negedge clk);
        tap_valid = 1'b0;
        check("R9 no writes after done", wr_next, 0);
        check("R9 still done", int'(cal_done), 1);
        check("R9 ref held", int'(ref_freq), 2 ** RLOG);

        // single-tap run: saturation corner (R6), alternating oscillator
        restart();
        ro_mode = 1;
        finish_cal(1, "B");
        check_table("B");
        check("B R6 saturated entry", got[TAPS - 1], 8191);
        check("B R5 midpoint entry", got[5], 4096);
        check("B R8 ref alternating", int'(ref_freq), 2 ** (RLOG - 1));

        // restart in mid-accumulation: stale hits discarded (R2)
        restart();
        ro_mode = 2;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            tap_valid = 1'b1;
            tap_count = '0;
        end
        restart();
        finish_cal(2, "C");
        check_table("C");
        check("C R8 ref all-low", int'(ref_freq), 0);
        check("C R9 done", int'(cal_done), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule